// File: doc/BRIEF.md
# Lighting Bus Controller Register File

This block is the register file and interrupt logic that sits beside the frame engine of a two-wire lighting-bus (DALI-style) interface. Software reaches it through a byte-wide port: a write strobe with address and data, and a read strobe with address whose result appears on `rdata` one cycle later. From these registers the block drives the direction and force-transmit controls into the engine. It also reports the effective direction and a 4-bit clock-select value.

The frame engine reports five kinds of single-cycle event pulses: end of forward-frame reception, end of backward-frame transmission, completion of a forced transmission, a received format error, and an interface failure. The first three raise an interrupt flag. Software clears that flag by writing the acknowledge bit of the control register. The last two raise an error flag, which clears when software reads the status register. The interrupt request line is the flag gated by an enable bit, taken from a flop.

There are three registers. The control register is at address 0. The status register is at address 1, with a fixed layout. The clock-select register is at address 2. Address 3 is unmapped.

Top module: `lbc_regs`

## Requirements
- R1: After reset, the control register reads 8'h00, the status register reads 8'h00, the clock-select register reads 8'h00, and `irq`, `ctrl_dir`, `ctrl_force`, `tx_active` and `clk_sel` are all 0.
- R2: The control register is at address 0. Bit 1 is the direction (0 = receive, 1 = transmit) and bit 0 is force-transmit. Both are set and cleared only by software writes. Both read back, and both appear on `ctrl_dir` and `ctrl_force` from the write edge on. Bits 7..3 read as 0.
- R3: `tx_active` and status bit 4 equal direction OR force-transmit. Force-transmit puts the engine in transmit state whatever the direction bit holds.
- R4: Control bit 2 is the acknowledge bit and always reads 0. Writing the control register with bit 2 = 1 clears the interrupt flag (status bit 6) at that edge. A control write with bit 2 = 0 leaves the flag as it was.
- R5: Any of `ev_rx_done`, `ev_tx_done` or `ev_force_done` sets the interrupt flag.
- R6: When a flag-setting event and its clear action fall in the same cycle, the flag ends up set. This holds for an event plus acknowledge, and for an error event plus status read.
- R7: The status register is at address 1. Only bit 7 (interrupt enable) is writable. Writes to bits 6..0 have no effect.
- R8: `irq` is a flop loaded each cycle with interrupt flag AND interrupt enable. It therefore follows a change of either one cycle later.
- R9: `ev_fmt_err` or `ev_if_fail` sets the error flag (status bit 5). A read strobe to the status address clears it, and that read returns the value before the clear.
- R10: Reads of any other address leave the error flag unchanged.
- R11: The clock-select register is at address 2. Bits 3..0 are stored, read back, drive `clk_sel` and appear in status bits 3..0. Bits 7..4 are ignored and read as 0.
- R12: `rdata` is loaded at the edge where `rd_en` is high and holds between reads. A read of an unmapped address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| ev_rx_done | input | 1 | Forward frame received (pulse) |
| ev_tx_done | input | 1 | Backward frame sent (pulse) |
| ev_force_done | input | 1 | Forced transmission finished (pulse) |
| ev_fmt_err | input | 1 | Received data format wrong (pulse) |
| ev_if_fail | input | 1 | Bus interface failure (pulse) |
| ctrl_dir | output | 1 | Software direction bit |
| ctrl_force | output | 1 | Force-transmit bit |
| tx_active | output | 1 | Effective transmit state |
| clk_sel | output | 4 | Clock-select field |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt flag is swept over every combination of its prior value, the three set events and a same-cycle acknowledge. This separates set priority, clearing and holding, and `irq` is checked against the enable. The error flag is swept over its prior value, both error sources, and a same-cycle read of either the status or the control address. This shows that only a status read clears it and that an event beats the clear. All 256 status write values, all control direction/force/acknowledge combinations and all 16 clock-select values are tried. The test writes set bits outside each register's fields, so that ignored bits would show up as mismatches.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int unsigned LBC_A_CTRL  = 0;
  localparam int unsigned LBC_A_STAT  = 1;
  localparam int unsigned LBC_A_CKSEL = 2;

  localparam int unsigned LBC_B_FORCE = 0;
  localparam int unsigned LBC_B_DIR   = 1;
  localparam int unsigned LBC_B_ACK   = 2;
  localparam int unsigned LBC_B_IE    = 7;

  localparam int unsigned LBC_CKSEL_W = 4;

  typedef struct packed {
    logic                   ie;
    logic                   irq_flag;
    logic                   err_flag;
    logic                   tx;
    logic [LBC_CKSEL_W-1:0] cksel;
  } lbc_stat_t;
endpackage

// File: rtl/lbc_ctrl_reg.sv
module lbc_ctrl_reg
  import lbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic                   dir_q,
  output logic                   force_q,
  output logic                   tx_q,
  output logic                   ie_q,
  output logic [LBC_CKSEL_W-1:0] cks_q,
  output logic                   ack_pulse
);
  logic wr_ctrl, wr_stat, wr_cks;
  logic unused_wbits;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(LBC_A_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(LBC_A_STAT));
  assign wr_cks  = wr_en && (addr == ADDR_W'(LBC_A_CKSEL));

  // acknowledge is never stored: the decoded write is the one-cycle clear
  assign ack_pulse    = wr_ctrl && wdata[LBC_B_ACK];
  assign unused_wbits = ^wdata[6:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= 1'b0;
      force_q <= 1'b0;
      tx_q    <= 1'b0;
    end else if (wr_ctrl) begin
      dir_q   <= wdata[LBC_B_DIR];
      force_q <= wdata[LBC_B_FORCE];
      tx_q    <= wdata[LBC_B_DIR] | wdata[LBC_B_FORCE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ie_q <= 1'b0;
    else if (wr_stat) ie_q <= wdata[LBC_B_IE];
  end

  always_ff @(posedge clk) begin
    if (rst)         cks_q <= '0;
    else if (wr_cks) cks_q <= wdata[LBC_CKSEL_W-1:0];
  end

  assert_tx_mirror_R3: assert property (@(posedge clk) disable iff (rst)
    tx_q == (dir_q | force_q));
  assert_force_tx_R3: assert property (@(posedge clk) disable iff (rst)
    force_q |-> tx_q);
endmodule

// File: rtl/lbc_sticky_flag.sv
module lbc_sticky_flag #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_i,
  output logic             q
);
  logic any_set;

  generate
    if (N_SRC == 1) begin : g_one
      assign any_set = set_i[0];
    end else begin : g_many
      assign any_set = |set_i;
    end
  endgenerate

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (any_set) q <= 1'b1;
    else if (clr_i)   q <= 1'b0;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(|set_i)) |=> !q);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(|set_i)) |=> $stable(q));
endmodule

// File: rtl/lbc_rdmux.sv
module lbc_rdmux
  import lbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dir_q,
  input  logic              force_q,
  input  lbc_stat_t         stat,
  output logic [7:0]        rdata
);
  logic [7:0] sel;

  always_comb begin
    sel = 8'h00;
    if (addr == ADDR_W'(LBC_A_CTRL)) begin
      sel[LBC_B_DIR]   = dir_q;
      sel[LBC_B_FORCE] = force_q;
    end else if (addr == ADDR_W'(LBC_A_STAT)) begin
      sel = stat;
    end else if (addr == ADDR_W'(LBC_A_CKSEL)) begin
      sel[LBC_CKSEL_W-1:0] = stat.cksel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= sel;
  end

  assert_ack_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(LBC_A_CTRL)) |=> (rdata[LBC_B_ACK] == 1'b0));
  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(LBC_A_CKSEL)) |=> (rdata == 8'h00));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/lbc_regs.sv
module lbc_regs
  import lbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic                   ev_rx_done,
  input  logic                   ev_tx_done,
  input  logic                   ev_force_done,
  input  logic                   ev_fmt_err,
  input  logic                   ev_if_fail,
  output logic                   ctrl_dir,
  output logic                   ctrl_force,
  output logic                   tx_active,
  output logic [LBC_CKSEL_W-1:0] clk_sel,
  output logic                   irq
);
  localparam int unsigned N_DONE = 3;
  localparam int unsigned N_ERR  = 2;

  logic                   ie_q, ack_pulse, irq_flag, err_flag, stat_rd;
  logic [LBC_CKSEL_W-1:0] cks_q;
  lbc_stat_t              stat;

  lbc_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(ctrl_dir), .force_q(ctrl_force), .tx_q(tx_active),
    .ie_q(ie_q), .cks_q(cks_q), .ack_pulse(ack_pulse)
  );

  lbc_sticky_flag #(.N_SRC(N_DONE)) u_irq_flag (
    .clk(clk), .rst(rst),
    .set_i({ev_force_done, ev_tx_done, ev_rx_done}),
    .clr_i(ack_pulse), .q(irq_flag)
  );

  assign stat_rd = rd_en && (addr == ADDR_W'(LBC_A_STAT));

  lbc_sticky_flag #(.N_SRC(N_ERR)) u_err_flag (
    .clk(clk), .rst(rst),
    .set_i({ev_if_fail, ev_fmt_err}),
    .clr_i(stat_rd), .q(err_flag)
  );

  always_comb begin
    stat.ie       = ie_q;
    stat.irq_flag = irq_flag;
    stat.err_flag = err_flag;
    stat.tx       = tx_active;
    stat.cksel    = cks_q;
  end

  lbc_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .dir_q(ctrl_dir), .force_q(ctrl_force), .stat(stat), .rdata(rdata)
  );

  assign clk_sel = cks_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_flag & ie_q;
  end

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie_q));
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && ie_q) |=> irq);
  assert_err_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !stat_rd) |=> err_flag);
endmodule

// File: tb/lbc_regs_tb.sv
module lbc_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ev_rx_done = 0, ev_tx_done = 0, ev_force_done = 0;
  logic       ev_fmt_err = 0, ev_if_fail = 0;
  logic       ctrl_dir, ctrl_force, tx_active, irq;
  logic [3:0] clk_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lbc_regs #(.ADDR_W(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev_rx_done(ev_rx_done),
    .ev_tx_done(ev_tx_done), .ev_force_done(ev_force_done),
    .ev_fmt_err(ev_fmt_err), .ev_if_fail(ev_if_fail), .ctrl_dir(ctrl_dir),
    .ctrl_force(ctrl_force), .tx_active(tx_active), .clk_sel(clk_sel),
    .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  // order: {rx, tx, force, fmt, ifail}
  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    {ev_rx_done, ev_tx_done, ev_force_done, ev_fmt_err, ev_if_fail} = ev;
    @(negedge clk);
    {ev_rx_done, ev_tx_done, ev_force_done, ev_fmt_err, ev_if_fail} = '0;
  endtask

  logic [7:0] d;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 outs", {3'd0, clk_sel, ctrl_dir}, 8'h00);
    chk("R1 force/tx", {6'd0, ctrl_force, tx_active}, 8'h00);
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 status", d, 8'h00);
    rd(2'd2, d); chk("R1 cksel", d, 8'h00);

    // R2 R3 R4 control sweep, upper bits set to show they read as 0
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, 8'hF8 | 8'(v));
      chk("R2 ctrl_dir", {7'd0, ctrl_dir}, {7'd0, v[1]});
      chk("R2 ctrl_force", {7'd0, ctrl_force}, {7'd0, v[0]});
      chk("R3 tx_active", {7'd0, tx_active}, {7'd0, v[1] | v[0]});
      rd(2'd0, d); chk("R2 R4 ctrl readback", d, {6'd0, v[1], v[0]});
      rd(2'd1, d); chk("R3 status bit4", {7'd0, d[4]}, {7'd0, v[1] | v[0]});
    end

    // R11 clock select sweep
    for (int k = 0; k < 16; k++) begin
      wr(2'd2, {~4'(k), 4'(k)});
      chk("R11 clk_sel", {4'd0, clk_sel}, {4'd0, 4'(k)});
      rd(2'd2, d); chk("R11 readback", d, {4'd0, 4'(k)});
      rd(2'd1, d); chk("R11 status mirror", {4'd0, d[3:0]}, {4'd0, 4'(k)});
    end

    // R7 status write sweep: dir=1, cksel=A, flags clear
    wr(2'd2, 8'h0A);
    wr(2'd0, 8'h06);
    rd(2'd1, d);
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v));
      rd(2'd1, d);
      chk("R7 status write", d, {v[7], 3'b001, 4'hA});
    end

    // R4 R5 R6 R8 interrupt flag sweep with enable on
    wr(2'd1, 8'h80);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 8; m++)
        for (int a = 0; a < 2; a++) begin
          logic exp;
          wr(2'd0, 8'h04);
          if (p == 1) pulse(5'b10000);
          @(negedge clk);
          {ev_rx_done, ev_tx_done, ev_force_done} = 3'(m);
          wr_en = a[0]; addr = 2'd0; wdata = 8'h04;
          @(negedge clk);
          {ev_rx_done, ev_tx_done, ev_force_done} = 3'd0; wr_en = 0;
          exp = (m != 0) ? 1'b1 : (a != 0) ? 1'b0 : p[0];
          chk("R8 irq lag", {7'd0, irq}, {7'd0, p[0]});
          rd(2'd1, d);
          chk("R4 R5 R6 flag", {7'd0, d[6]}, {7'd0, exp});
          chk("R8 irq", {7'd0, irq}, {7'd0, exp});
        end
    // R8 enable off gates irq
    pulse(5'b01000);
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R8 irq gated", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h80);
    @(negedge clk);
    chk("R8 irq reenabled", {7'd0, irq}, 8'h01);

    // R6 R9 R10 error flag sweep
    for (int p = 0; p < 2; p++)
      for (int e = 0; e < 4; e++)
        for (int r = 0; r < 3; r++) begin
          logic exp;
          logic [1:0] ra;
          ra = (r == 1) ? 2'd1 : 2'd0;
          rd(2'd1, d);
          if (p == 1) pulse(5'b00010);
          @(negedge clk);
          {ev_fmt_err, ev_if_fail} = 2'(e);
          rd_en = (r != 0); addr = ra;
          @(negedge clk);
          {ev_fmt_err, ev_if_fail} = 2'd0; rd_en = 0;
          if (r == 1)
            chk("R9 read returns pre-clear", {7'd0, rdata[5]}, {7'd0, p[0]});
          exp = (e != 0) || (p == 1 && r != 1);
          rd(2'd1, d);
          chk("R6 R9 R10 err flag", {7'd0, d[5]}, {7'd0, exp});
        end

    // R12 unmapped read and hold
    rd(2'd3, d); chk("R12 unmapped", d, 8'h00);
    wr(2'd2, 8'h05);
    rd(2'd2, d);
    repeat (3) @(negedge clk);
    chk("R12 hold", rdata, 8'h05);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule